// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns the operand fields of a load or store into the address the data memory will see. A request carries a mode code, a base register value, an index register value, a two-bit scale code, a displacement with a width selector, and the current program counter. One cycle after an accepted request the block presents the registered effective address with a one-cycle valid strobe. For the two base-updating modes it also presents a write-back value and its enable, so the register file can update the base in step with the access.

One mode is not a plain computation. In memory-indirect mode the block reads a pointer word through its own valid/ready read port at the base address and, when the word returns, presents that word as the final address. While this two-step sequence runs, a busy flag is high and every new request is ignored. The register file and memory contents sit outside the block.

Top module: `eff_addr_unit`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` is 1 and `busy` is 0; for a non-indirect mode, `ea_valid` is 1 for exactly the following cycle with the address in `ea`, and 0 in every cycle with no such result.
- R2: The displacement is sign-extended before any add according to `disp_size`: 00 uses bits 7:0, 01 uses bits 15:0, 10 and 11 use all 32 bits.
- R3: Mode 0 (displacement) gives base plus extended displacement; mode 7 is reserved and behaves exactly as mode 0.
- R4: Mode 1 (index-base) gives base plus index.
- R5: Mode 2 (auto-increment) gives the base itself as the address, with `wb_en` 1 and `wb_data` equal to base plus one.
- R6: Mode 3 (auto-index) gives base plus extended displacement as the address, with `wb_en` 1 and `wb_data` equal to that same sum.
- R7: Mode 4 (scaled) gives base plus (index shifted left by `scale`) plus extended displacement; scale code 00, 01, 10, 11 means a factor of 1, 2, 4, 8.
- R8: Mode 5 (PC-relative) gives `pc` plus extended displacement.
- R9: `wb_en` is 1 only in a cycle where `ea_valid` is 1 and only for modes 2 and 3; it is 0 for every other mode.
- R10: Mode 6 (memory-indirect) raises `mem_req_valid` in the cycle after acceptance with `mem_req_addr` equal to the base, holding both unchanged until a cycle with `mem_req_ready` 1; after the cycle where `mem_rsp_valid` is 1, `ea_valid` is 1 with `ea` equal to the returned `mem_rsp_data` and `wb_en` 0.
- R11: `busy` is 1 from the cycle after an indirect request is accepted up to, but not including, the cycle its final address is shown; requests presented while `busy` is 1 are ignored and produce no result.
- R12: After reset, `ea_valid`, `wb_en`, `busy` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code (0 to 7) |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_scale | input | 2 | Index shift amount code |
| req_disp | input | 32 | Displacement field, low bits significant |
| req_disp_size | input | 2 | Displacement width selector |
| req_pc | input | 32 | Program counter of the access |
| busy | output | 1 | Indirect sequence in progress |
| ea_valid | output | 1 | Effective address strobe |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base write-back enable |
| wb_data | output | 32 | Base write-back value |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_addr | output | 32 | Pointer read address |
| mem_req_ready | input | 1 | Pointer read accepted |
| mem_rsp_valid | input | 1 | Pointer word returned |
| mem_rsp_data | input | 32 | Returned pointer word |

## Verification
A wrong adder input or a wrong sign-extension lane shows in `ea` or `wb_data` on the very next cycle after the request, so every random request is compared at that cycle against a bench model. A sequencer stuck in the wrong state shows as `busy` or `mem_req_valid` at the wrong level, a read address that moves while the port stalls, or a final strobe that comes early, late or not at all. A request wrongly accepted during the indirect sequence shows as a strobe in the cycle right after the indirect result.

// File: rtl/eau_pkg.sv
package eau_pkg;

    typedef enum logic [2:0] {
        AM_DISP   = 3'd0,
        AM_IDXB   = 3'd1,
        AM_AINC   = 3'd2,
        AM_AIDX   = 3'd3,
        AM_SCALED = 3'd4,
        AM_PCREL  = 3'd5,
        AM_INDIR  = 3'd6,
        AM_RSVD   = 3'd7
    } am_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_e;

    localparam int unsigned NARROW_W = 8;
    localparam int unsigned MID_W    = 16;

endpackage

// File: rtl/eau_disp_ext.sv
module eau_disp_ext #(
    parameter int unsigned AW  = 32,
    parameter int unsigned NW  = eau_pkg::NARROW_W,
    parameter int unsigned MW  = eau_pkg::MID_W
) (
    input  logic [AW-1:0] disp_i,
    input  logic [1:0]    size_i,
    output logic [AW-1:0] ext_o
);
    localparam int unsigned NLANE = 2;
    localparam int unsigned LW [NLANE] = '{NW, MW};

    logic [AW-1:0] lane [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int unsigned W = LW[g];
        assign lane[g] = {{(AW-W){disp_i[W-1]}}, disp_i[W-1:0]};
    end

    always_comb begin
        case (size_i)
            2'd0:    ext_o = lane[0];
            2'd1:    ext_o = lane[1];
            default: ext_o = disp_i;
        endcase
    end
endmodule

// File: rtl/eau_addr_calc.sv
module eau_addr_calc
    import eau_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned SCW = 2
) (
    input  am_mode_e      mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    input  logic [SCW-1:0] scale_i,
    input  logic [AW-1:0] ext_i,
    input  logic [AW-1:0] pc_i,
    output logic [AW-1:0] addr_o,
    output logic          wb_en_o,
    output logic [AW-1:0] wb_data_o
);
    logic [AW-1:0] base_disp;
    logic [AW-1:0] scaled_idx;
    logic [AW-1:0] base_inc;

    assign base_disp  = base_i + ext_i;
    assign scaled_idx = index_i << scale_i;
    assign base_inc   = base_i + AW'(1);

    always_comb begin
        addr_o    = base_disp;
        wb_en_o   = 1'b0;
        wb_data_o = base_disp;
        case (mode_i)
            AM_DISP, AM_RSVD: addr_o = base_disp;
            AM_IDXB:          addr_o = base_i + index_i;
            AM_AINC: begin
                addr_o    = base_i;
                wb_en_o   = 1'b1;
                wb_data_o = base_inc;
            end
            AM_AIDX: begin
                addr_o    = base_disp;
                wb_en_o   = 1'b1;
                wb_data_o = base_disp;
            end
            AM_SCALED:        addr_o = base_disp + scaled_idx;
            AM_PCREL:         addr_o = pc_i + ext_i;
            AM_INDIR:         addr_o = base_i;
            default:          addr_o = base_disp;
        endcase
    end
endmodule

// File: rtl/eau_seq.sv
module eau_seq
    import eau_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] ptr_addr_i,
    input  logic          rd_ready_i,
    input  logic          rsp_valid_i,
    output logic          rd_valid_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          busy_o,
    output logic          done_o
);
    typedef struct packed {
        sq_state_e     state;
        logic [AW-1:0] addr;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        done_o = 1'b0;
        case (seq_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    seq_d.state = SQ_ISSUE;
                    seq_d.addr  = ptr_addr_i;
                end
            end
            SQ_ISSUE: begin
                if (rd_ready_i) seq_d.state = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (rsp_valid_i) begin
                    seq_d.state = SQ_IDLE;
                    done_o      = 1'b1;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SQ_IDLE;
            seq_q.addr  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_valid_o = (seq_q.state == SQ_ISSUE);
    assign rd_addr_o  = seq_q.addr;
    assign busy_o     = (seq_q.state != SQ_IDLE);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

    // R10
    rd_during_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> busy_o);
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import eau_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned SCW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_mode,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_index,
    input  logic [SCW-1:0] req_scale,
    input  logic [AW-1:0] req_disp,
    input  logic [1:0]    req_disp_size,
    input  logic [AW-1:0] req_pc,
    output logic          busy,
    output logic          ea_valid,
    output logic [AW-1:0] ea,
    output logic          wb_en,
    output logic [AW-1:0] wb_data,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data
);
    typedef struct packed {
        logic          ea_valid;
        logic [AW-1:0] ea;
        logic          wb_en;
        logic [AW-1:0] wb_data;
    } out_reg_t;

    out_reg_t out_d, out_q;

    am_mode_e      mode;
    logic [AW-1:0] ext_disp;
    logic [AW-1:0] calc_addr;
    logic          calc_wb_en;
    logic [AW-1:0] calc_wb_data;
    logic          accept;
    logic          start_ind;
    logic          seq_busy;
    logic          seq_done;

    assign mode      = am_mode_e'(req_mode);
    assign accept    = req_valid && !seq_busy;
    assign start_ind = accept && (mode == AM_INDIR);

    eau_disp_ext #(.AW(AW)) u_ext (
        .disp_i (req_disp),
        .size_i (req_disp_size),
        .ext_o  (ext_disp)
    );

    eau_addr_calc #(.AW(AW), .SCW(SCW)) u_calc (
        .mode_i    (mode),
        .base_i    (req_base),
        .index_i   (req_index),
        .scale_i   (req_scale),
        .ext_i     (ext_disp),
        .pc_i      (req_pc),
        .addr_o    (calc_addr),
        .wb_en_o   (calc_wb_en),
        .wb_data_o (calc_wb_data)
    );

    eau_seq #(.AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_ind),
        .ptr_addr_i  (req_base),
        .rd_ready_i  (mem_req_ready),
        .rsp_valid_i (mem_rsp_valid),
        .rd_valid_o  (mem_req_valid),
        .rd_addr_o   (mem_req_addr),
        .busy_o      (seq_busy),
        .done_o      (seq_done)
    );

    always_comb begin
        out_d          = out_q;
        out_d.ea_valid = 1'b0;
        out_d.wb_en    = 1'b0;
        if (seq_done) begin
            out_d.ea_valid = 1'b1;
            out_d.ea       = mem_rsp_data;
        end else if (accept && (mode != AM_INDIR)) begin
            out_d.ea_valid = 1'b1;
            out_d.ea       = calc_addr;
            out_d.wb_en    = calc_wb_en;
            out_d.wb_data  = calc_wb_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign busy     = seq_busy;
    assign ea_valid = out_q.ea_valid;
    assign ea       = out_q.ea;
    assign wb_en    = out_q.wb_en;
    assign wb_data  = out_q.wb_data;

    // R9
    wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ea_valid);

    // R11
    no_result_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ea_valid);

    // R5
    ainc_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_mode == 3'd2)
            |=> (wb_en && ea == $past(req_base) && wb_data == $past(req_base) + AW'(1)));

    // R10
    indir_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req_valid && mem_rsp_valid)
            |=> (ea_valid && !wb_en && !busy && ea == $past(mem_rsp_data)));
endmodule

// File: tb/eff_addr_unit_test.sv
module eff_addr_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [31:0] req_base = '0, req_index = '0, req_disp = '0, req_pc = '0;
    logic [1:0]  req_scale = '0, req_disp_size = '0;
    logic        busy, ea_valid, wb_en, mem_req_valid;
    logic [31:0] ea, wb_data, mem_req_addr;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eff_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_base(req_base), .req_index(req_index), .req_scale(req_scale),
        .req_disp(req_disp), .req_disp_size(req_disp_size), .req_pc(req_pc),
        .busy(busy), .ea_valid(ea_valid), .ea(ea), .wb_en(wb_en), .wb_data(wb_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [31:0] d, input logic [1:0] sz);
        case (sz)
            2'd0:    return {{24{d[7]}}, d[7:0]};
            2'd1:    return {{16{d[15]}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_ea(input logic [2:0] m, input logic [31:0] b,
        input logic [31:0] x, input logic [1:0] s, input logic [31:0] d,
        input logic [1:0] sz, input logic [31:0] p);
        case (m)
            3'd1:    return b + x;
            3'd2:    return b;
            3'd4:    return b + (x << s) + sx(d, sz);
            3'd5:    return p + sx(d, sz);
            default: return b + sx(d, sz);
        endcase
    endfunction

    function automatic logic [31:0] exp_wb(input logic [2:0] m, input logic [31:0] b,
        input logic [31:0] d, input logic [1:0] sz);
        return (m == 3'd2) ? b + 32'd1 : b + sx(d, sz);
    endfunction

    function automatic string rtag(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd7: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // drive at negedge, check at next negedge (one register stage)
    task automatic one_req(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
        input logic [1:0] s, input logic [31:0] d, input logic [1:0] sz, input logic [31:0] p);
        logic [31:0] e;
        logic        we;
        req_valid = 1'b1; req_mode = m; req_base = b; req_index = x;
        req_scale = s; req_disp = d; req_disp_size = sz; req_pc = p;
        @(negedge clk);
        req_valid = 1'b0;
        e  = exp_ea(m, b, x, s, d, sz, p);
        we = (m == 3'd2 || m == 3'd3);
        chk(ea_valid === 1'b1, "R1 ea_valid", {31'd0, ea_valid}, 32'd1);
        chk(ea === e, rtag(m), ea, e);
        chk(wb_en === we, "R9 wb_en", {31'd0, wb_en}, {31'd0, we});
        if (we) chk(wb_data === exp_wb(m, b, d, sz), "R5/R6 wb_data", wb_data, exp_wb(m, b, d, sz));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(ea_valid === 1'b0, "R12 ea_valid", {31'd0, ea_valid}, 0);
        chk(wb_en === 1'b0, "R12 wb_en", {31'd0, wb_en}, 0);
        chk(busy === 1'b0, "R12 busy", {31'd0, busy}, 0);
        chk(mem_req_valid === 1'b0, "R12 mem_req_valid", {31'd0, mem_req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 directed sign extension: 8-bit negative, 16-bit negative, full width
        one_req(3'd0, 32'h0000_1000, 0, 0, 32'hFFFF_FF80, 2'd0, 0);
        one_req(3'd0, 32'h0000_1000, 0, 0, 32'h1234_8000, 2'd1, 0);
        one_req(3'd0, 32'h0000_1000, 0, 0, 32'h1234_00FF, 2'd2, 0);
        one_req(3'd0, 32'h0000_1000, 0, 0, 32'h8000_0001, 2'd3, 0);
        chk(ea === 32'h8000_1001, "R2 size 11 full width", ea, 32'h8000_1001);
        // R7 each scale code
        for (int s = 0; s < 4; s++) one_req(3'd4, 32'h100, 32'h3, 2'(s), 32'h4, 2'd0, 0);
        // R5 auto-increment wrap, R6 auto-index negative
        one_req(3'd2, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        chk(wb_data === 32'h0, "R5 wrap", wb_data, 32'h0);
        one_req(3'd3, 32'h200, 0, 0, 32'h0000_00F0, 2'd0, 0);
        // R8 pc-relative, R3 reserved
        one_req(3'd5, 32'hDEAD, 0, 0, 32'hFFFC, 2'd1, 32'h4000);
        one_req(3'd7, 32'h10, 0, 0, 32'h20, 2'd0, 0);
        // R1 idle cycle produces nothing
        @(negedge clk);
        chk(ea_valid === 1'b0, "R1 no request", {31'd0, ea_valid}, 0);

        // R10 / R11 indirect sequence with a stalled read port
        req_valid = 1'b1; req_mode = 3'd6; req_base = 32'hABCD_0000;
        @(negedge clk);
        chk(busy === 1'b1, "R11 busy after accept", {31'd0, busy}, 1);
        chk(mem_req_valid === 1'b1, "R10 read issued", {31'd0, mem_req_valid}, 1);
        chk(mem_req_addr === 32'hABCD_0000, "R10 read addr", mem_req_addr, 32'hABCD_0000);
        chk(ea_valid === 1'b0, "R10 no early ea", {31'd0, ea_valid}, 0);
        req_mode = 3'd0; req_base = 32'h5555_0000; req_disp = 0;
        @(negedge clk);
        chk(mem_req_valid === 1'b1, "R10 read held", {31'd0, mem_req_valid}, 1);
        chk(mem_req_addr === 32'hABCD_0000, "R10 addr stable", mem_req_addr, 32'hABCD_0000);
        chk(ea_valid === 1'b0, "R11 busy ignores request", {31'd0, ea_valid}, 0);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(mem_req_valid === 1'b0, "R10 read done", {31'd0, mem_req_valid}, 0);
        chk(busy === 1'b1, "R11 busy waiting", {31'd0, busy}, 1);
        chk(ea_valid === 1'b0, "R11 busy ignores request", {31'd0, ea_valid}, 0);
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0BAD_F00D;
        @(negedge clk);
        mem_rsp_valid = 1'b0; req_valid = 1'b0;
        chk(ea_valid === 1'b1, "R10 final valid", {31'd0, ea_valid}, 1);
        chk(ea === 32'h0BAD_F00D, "R10 final ea", ea, 32'h0BAD_F00D);
        chk(wb_en === 1'b0, "R9 no wb on indirect", {31'd0, wb_en}, 0);
        chk(busy === 1'b0, "R11 busy clear", {31'd0, busy}, 0);
        @(negedge clk);
        chk(ea_valid === 1'b0, "R11 no late result", {31'd0, ea_valid}, 0);

        // random non-indirect requests, checked against the bench model
        for (int i = 0; i < 400; i++) begin
            logic [2:0] m;
            m = 3'($urandom % 7);
            if (m == 3'd6) m = 3'd7;
            one_req(m, $urandom, $urandom, 2'($urandom), $urandom, 2'($urandom), $urandom);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule